// File: doc/BRIEF.md
# Decoder control and status register I2C slave

This block is the serial control port of a broadcast audio decoder. It is an I2C slave that holds seven control registers. Their fields drive the decoder's level trim, oscillator and filter trims, separation trims, test switches and output-mode bits. A strap input picks one of two device addresses, so that two decoders can share one bus.

A write transaction carries the device address, a register pointer byte and then any number of data bytes. Each data byte lands in the register that the pointer selects, and the pointer then steps to the next register, wrapping after the last one. A read transaction returns a status byte, repeated for as long as the master acknowledges. The status byte holds a power-on flag and detector flags taken from the decoder. While the filter-test bit is set, two of its positions carry filter-lock flags instead.

The SDA output is open-drain: the block only pulls the line low or releases it. SCL and SDA pass through a short synchroniser, and all bus events are decoded in the system clock domain.

Top module: `dec_ctl_i2c_slave`

## Requirements
- R1: After reset the register views are: reg0 = 09h, reg1 = 1Fh, reg2 = 88h, reg3 = 1Fh, reg4 = 1Fh, reg5 = 1Fh, reg6 = 01h, and `sda_pull` is 0.
- R2: With `addr_sel` = 0 the address bytes 80h (write) and 81h (read) are acknowledged. With `addr_sel` = 1 the address bytes 8Ah and 8Bh are acknowledged and 80h is not.
- R3: An address byte that does not match is not acknowledged, and the block ignores the following bytes until the next START. Registers are left unchanged.
- R4: In a write, the pointer byte and every data byte are acknowledged. After each data byte the pointer advances by one, and from 6 it wraps to 0. Registers change only when a data byte is written.
- R5: Only bits 3:0 of the pointer byte are decoded. A pointer value from 7 to 15 stores nothing, and the next data byte goes to register 0.
- R6: Field map. reg0: bit 6 `bypass_att`, bit 5 `dac_test`, bit 4 `flt_test`, bits 3:0 `lvl_trim`. reg1 bits 5:0 `stvco_trim`. reg2: bits 7:4 `sapvco_trim`, bits 3:0 `sapflt_trim`. reg3 bits 5:0 `stflt_trim`. reg4 bits 5:0 `sep_hf_trim`. reg5 bits 5:0 `sep_lf_trim`. reg6: bit 3 `sel_sap`, bit 2 `force_mono`, bit 1 `sap_always`, bit 0 `unmute`. Bits outside these fields are discarded and read as 0 in the register view.
- R7: The status byte is bit 7 power-on flag, bit 6 `stereo_det`, bit 5 `sap_det`, bit 4 `noise_det`, bits 3:2 zero, bit 1 `vco_win_lo`, bit 0 `vco_win_hi`. It is sent MSB first.
- R8: While `flt_test` is 1, status bit 5 carries `stflt_lock` and status bit 4 carries `sapflt_lock`.
- R9: The power-on flag is 1 after reset and becomes 0 once the first status byte has been fully sent.
- R10: `sda_pull` is high only in an acknowledge slot or while a 0 data bit is being sent. A STOP releases SDA and returns the block to idle.
- R11: While the master acknowledges a status byte, the block sends the status byte again. A master NACK ends the read and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Address strap: 0 selects 80h/81h, 1 selects 8Ah/8Bh |
| stereo_det | input | 1 | Stereo pilot detected |
| sap_det | input | 1 | Second-program carrier detected |
| noise_det | input | 1 | Excess noise detected |
| stflt_lock | input | 1 | Stereo filter trim within window |
| sapflt_lock | input | 1 | Second-program filter trim within window |
| vco_win_lo | input | 1 | Second-program VCO window flag, low side |
| vco_win_hi | input | 1 | Second-program VCO window flag, high side |
| bypass_att | output | 1 | Bypass the input level stage |
| dac_test | output | 1 | Trim DAC test mode |
| flt_test | output | 1 | Filter trim test mode |
| lvl_trim | output | 4 | Input level trim |
| stvco_trim | output | 6 | Stereo VCO free-run trim |
| sapvco_trim | output | 4 | Second-program VCO free-run trim |
| sapflt_trim | output | 4 | Second-program filter trim |
| stflt_trim | output | 6 | Stereo and noise-reduction filter trim |
| sep_hf_trim | output | 6 | High-frequency separation trim |
| sep_lf_trim | output | 6 | Low-frequency separation trim |
| sel_sap | output | 1 | Select second program instead of stereo |
| force_mono | output | 1 | Force mono output |
| sap_always | output | 1 | Select second program even without carrier detect |
| unmute | output | 1 | 1 releases the output mute |

## Verification
The bench goes after the pointer edges. A burst that starts at register 5 must wrap into register 0; a design that stops at 6 or runs into a phantom register 7 would leave register 0 unchanged. A pointer with a non-zero upper nibble, and one at 9, show whether the upper nibble is decoded and whether an out-of-range pointer corrupts real registers. Reads check that the power-on flag survives exactly one status byte. They also check that the filter-test bit swaps the detector positions, which a design with the wrong multiplexer polarity would report backwards. Address tests with both strap settings and foreign addresses show whether a design acknowledges the wrong device or keeps writing after a NACK.

// File: rtl/dec_ctl_i2c_slave.sv
module dec_ctl_i2c_slave #(
  parameter logic [6:0] ADDR_LO     = 7'h40,
  parameter logic [6:0] ADDR_HI     = 7'h45,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic       addr_sel,
  input  logic       stereo_det,
  input  logic       sap_det,
  input  logic       noise_det,
  input  logic       stflt_lock,
  input  logic       sapflt_lock,
  input  logic       vco_win_lo,
  input  logic       vco_win_hi,
  output logic       bypass_att,
  output logic       dac_test,
  output logic       flt_test,
  output logic [3:0] lvl_trim,
  output logic [5:0] stvco_trim,
  output logic [3:0] sapvco_trim,
  output logic [3:0] sapflt_trim,
  output logic [5:0] stflt_trim,
  output logic [5:0] sep_hf_trim,
  output logic [5:0] sep_lf_trim,
  output logic       sel_sap,
  output logic       force_mono,
  output logic       sap_always,
  output logic       unmute
);

  localparam logic [3:0] LAST_REG = 4'd6;
  localparam logic [3:0] BYTE_LEN = 4'd8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } st_t;

  st_t state;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  logic [7:0] shreg, txsh;
  logic [3:0] bitcnt, ptr;
  logic       rw, mack, por;

  logic [6:0] r0;
  logic [5:0] r1, r3, r4, r5;
  logic [7:0] r2;
  logic [3:0] r6;

  logic [6:0] dev_addr;
  logic [7:0] status_now;
  logic       addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign dev_addr = addr_sel ? ADDR_HI : ADDR_LO;
  assign addr_hit = (shreg[7:1] == dev_addr);

  assign status_now = {por, stereo_det,
                       r0[4] ? stflt_lock  : sap_det,
                       r0[4] ? sapflt_lock : noise_det,
                       2'b00, vco_win_lo, vco_win_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
      shreg    <= '0;
      txsh     <= '0;
      bitcnt   <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      por      <= 1'b1;
      r0       <= 7'h09;
      r1       <= 6'h1F;
      r2       <= 8'h88;
      r3       <= 6'h1F;
      r4       <= 6'h1F;
      r5       <= 6'h1F;
      r6       <= 4'h1;
    end else if (start_det) begin
      state    <= S_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_SUB, S_WDAT: begin
          if (scl_rise && bitcnt != BYTE_LEN) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (scl_fall && bitcnt == BYTE_LEN) begin
            bitcnt <= '0;
            if (state == S_ADDR) begin
              if (addr_hit) begin
                rw       <= shreg[0];
                sda_pull <= 1'b1;
                state    <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_SUB) begin
              ptr      <= shreg[3:0];
              sda_pull <= 1'b1;
              state    <= S_SACK;
            end else begin
              case (ptr)
                4'd0: r0 <= shreg[6:0];
                4'd1: r1 <= shreg[5:0];
                4'd2: r2 <= shreg;
                4'd3: r3 <= shreg[5:0];
                4'd4: r4 <= shreg[5:0];
                4'd5: r5 <= shreg[5:0];
                4'd6: r6 <= shreg[3:0];
                default: ;
              endcase
              ptr      <= (ptr >= LAST_REG) ? 4'd0 : ptr + 4'd1;
              sda_pull <= 1'b1;
              state    <= S_WACK;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              txsh     <= status_now;
              sda_pull <= ~status_now[7];
              bitcnt   <= 4'd1;
              state    <= S_RDAT;
            end else begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              state    <= S_SUB;
            end
          end
        end
        S_SACK, S_WACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            bitcnt   <= '0;
            state    <= S_WDAT;
          end
        end
        S_RDAT: begin
          if (scl_fall) begin
            if (bitcnt == BYTE_LEN) begin
              sda_pull <= 1'b0;
              por      <= 1'b0;
              state    <= S_RACK;
            end else begin
              sda_pull <= ~txsh[~bitcnt[2:0]];
              bitcnt   <= bitcnt + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              txsh     <= status_now;
              sda_pull <= ~status_now[7];
              bitcnt   <= 4'd1;
              state    <= S_RDAT;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign bypass_att  = r0[6];
  assign dac_test    = r0[5];
  assign flt_test    = r0[4];
  assign lvl_trim    = r0[3:0];
  assign stvco_trim  = r1;
  assign sapvco_trim = r2[7:4];
  assign sapflt_trim = r2[3:0];
  assign stflt_trim  = r3;
  assign sep_hf_trim = r4;
  assign sep_lf_trim = r5;
  assign sel_sap     = r6[3];
  assign force_mono  = r6[2];
  assign sap_always  = r6[1];
  assign unmute      = r6[0];

  AST_SDA_LOW_IN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (state inside {S_AACK, S_SACK, S_WACK, S_RDAT})); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE && !sda_pull)); // R10
  AST_NACK_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && scl_fall && bitcnt == BYTE_LEN && !addr_hit && !start_det && !stop_det)
      |=> (state == S_IDLE && !sda_pull)); // R3
  AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({r0, r1, r2, r3, r4, r5, r6}) |-> $past(state) == S_WDAT); // R4
  AST_POR_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(state) == S_RDAT); // R9
  AST_PTR_IN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WACK) |-> ptr <= LAST_REG); // R5

endmodule

// File: tb/dec_ctl_i2c_slave_tb_top.sv
module dec_ctl_i2c_slave_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, sda_line;
  logic addr_sel = 1'b0;
  logic stereo_det = 0, sap_det = 0, noise_det = 0;
  logic stflt_lock = 0, sapflt_lock = 0, vco_win_lo = 0, vco_win_hi = 0;
  logic bypass_att, dac_test, flt_test, sel_sap, force_mono, sap_always, unmute;
  logic [3:0] lvl_trim, sapvco_trim, sapflt_trim;
  logic [5:0] stvco_trim, stflt_trim, sep_hf_trim, sep_lf_trim;

  assign sda_line = sda_m & ~sda_pull;

  dec_ctl_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .addr_sel(addr_sel), .stereo_det(stereo_det), .sap_det(sap_det), .noise_det(noise_det),
    .stflt_lock(stflt_lock), .sapflt_lock(sapflt_lock), .vco_win_lo(vco_win_lo),
    .vco_win_hi(vco_win_hi), .bypass_att(bypass_att), .dac_test(dac_test),
    .flt_test(flt_test), .lvl_trim(lvl_trim), .stvco_trim(stvco_trim),
    .sapvco_trim(sapvco_trim), .sapflt_trim(sapflt_trim), .stflt_trim(stflt_trim),
    .sep_hf_trim(sep_hf_trim), .sep_lf_trim(sep_lf_trim), .sel_sap(sel_sap),
    .force_mono(force_mono), .sap_always(sap_always), .unmute(unmute)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // {pointer byte, data byte, expected register view}; R5 on the last two rows
  localparam logic [23:0] VEC [0:9] = '{
    24'h00FF7F, 24'h002323, 24'h01C505, 24'h02A7A7, 24'h033E3E,
    24'h048101, 24'h056A2A, 24'h06F606, 24'hF11212, 24'h360909
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_view(input int idx);
    case (idx)
      0: return {1'b0, bypass_att, dac_test, flt_test, lvl_trim};
      1: return {2'b0, stvco_trim};
      2: return {sapvco_trim, sapflt_trim};
      3: return {2'b0, stflt_trim};
      4: return {2'b0, sep_hf_trim};
      5: return {2'b0, sep_lf_trim};
      default: return {4'b0, sel_sap, force_mono, sap_always, unmute};
    endcase
  endfunction

  task automatic wq();
    repeat (10) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = (sda_line == 1'b0);
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] dev, input logic [7:0] sub,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                           input int n, output int acks);
    bit a;
    acks = 0;
    i2c_start();
    wbyte(dev, a); acks += int'(a);
    wbyte(sub, a); acks += int'(a);
    wbyte(d0, a);  acks += int'(a);
    if (n > 1) begin wbyte(d1, a); acks += int'(a); end
    if (n > 2) begin wbyte(d2, a); acks += int'(a); end
    i2c_stop();
  endtask

  task automatic read_seq(input logic [7:0] dev, input bit two,
                          output logic [7:0] b0, output logic [7:0] b1, output bit ack);
    i2c_start();
    wbyte(dev, ack);
    rbyte(two, b0);
    b1 = 8'h00;
    if (two) rbyte(1'b0, b1);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int acks;
    bit ak;
    logic [7:0] b0, b1;
    logic [7:0] saved [0:6];

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1 reg0", reg_view(0), 8'h09);
    chk("R1 reg1", reg_view(1), 8'h1F);
    chk("R1 reg2", reg_view(2), 8'h88);
    chk("R1 reg3", reg_view(3), 8'h1F);
    chk("R1 reg4", reg_view(4), 8'h1F);
    chk("R1 reg5", reg_view(5), 8'h1F);
    chk("R1 reg6", reg_view(6), 8'h01);
    chk("R1 sda released", sda_pull, 1'b0);

    stereo_det = 1; sap_det = 0; noise_det = 1; stflt_lock = 0; sapflt_lock = 1;
    vco_win_lo = 1; vco_win_hi = 0;
    read_seq(8'h81, 1'b0, b0, b1, ak);
    chk("R2 read address 81h ack", ak, 1'b1);
    chk("R7 R9 first status", b0, 8'hD2);
    read_seq(8'h81, 1'b0, b0, b1, ak);
    chk("R9 flag cleared after first read", b0, 8'h52);

    stereo_det = 0; sap_det = 1; noise_det = 0; vco_win_lo = 0; vco_win_hi = 1;
    read_seq(8'h81, 1'b0, b0, b1, ak);
    chk("R7 second flag pattern", b0, 8'h21);

    for (int k = 0; k < 10; k++) begin
      write_seq(8'h80, VEC[k][23:16], VEC[k][15:8], 8'h00, 8'h00, 1, acks);
      chk("R4 acks per single write", acks, 3);
      chk($sformatf("R6 field map row %0d", k), reg_view(int'(VEC[k][19:16])), VEC[k][7:0]);
    end

    write_seq(8'h80, 8'h00, 8'h10, 8'h00, 8'h00, 1, acks);
    read_seq(8'h81, 1'b0, b0, b1, ak);
    chk("R8 filter test swaps bits 5:4", b0, 8'h11);
    stflt_lock = 1;
    read_seq(8'h81, 1'b0, b0, b1, ak);
    chk("R8 stereo filter lock on bit 5", b0, 8'h31);

    write_seq(8'h80, 8'h05, 8'h11, 8'h22, 8'h33, 3, acks);
    chk("R4 burst acks", acks, 5);
    chk("R4 burst reg5", reg_view(5), 8'h11);
    chk("R4 burst reg6", reg_view(6), 8'h02);
    chk("R4 wrap to reg0", reg_view(0), 8'h33);

    for (int i = 1; i < 7; i++) saved[i] = reg_view(i);
    write_seq(8'h80, 8'h09, 8'h3C, 8'h15, 8'h00, 2, acks);
    chk("R5 pointer 9 then reg0", reg_view(0), 8'h15);
    for (int i = 1; i < 7; i++) chk("R5 pointer 9 stores nothing", reg_view(i), saved[i]);

    saved[2] = reg_view(2);
    write_seq(8'h8A, 8'h02, 8'h00, 8'h00, 8'h00, 1, acks);
    chk("R3 foreign address gets no ack", acks, 0);
    chk("R3 register untouched", reg_view(2), saved[2]);
    read_seq(8'h8B, 1'b0, b0, b1, ak);
    chk("R3 foreign read address", ak, 1'b0);

    addr_sel = 1'b1;
    repeat (5) @(negedge clk);
    write_seq(8'h8A, 8'h03, 8'h07, 8'h00, 8'h00, 1, acks);
    chk("R2 strap high write acks", acks, 3);
    chk("R2 strap high write lands", reg_view(3), 8'h07);
    write_seq(8'h80, 8'h03, 8'h2A, 8'h00, 8'h00, 1, acks);
    chk("R2 low address refused with strap high", acks, 0);
    chk("R2 register kept", reg_view(3), 8'h07);

    read_seq(8'h8B, 1'b1, b0, b1, ak);
    chk("R2 strap high read ack", ak, 1'b1);
    chk("R11 first byte", b0, 8'h31);
    chk("R11 repeated byte", b1, 8'h31);
    repeat (5) @(negedge clk);
    chk("R10 released after stop", sda_pull, 1'b0);
    chk("R11 released after nack", sda_line, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule